// File: doc/BRIEF.md
# Machine-Mode Trap and CSR Unit

This block holds the machine-mode control and status registers of a 32-bit in-order integer pipeline and decides, once per cycle, whether the pipeline must be redirected. The pipeline hands it one CSR read-modify-write request, up to six synchronous fault requests for the instruction at the trap point, three interrupt request lines, and an MRET request. In the same cycle it returns the old CSR value and, when a trap or return is taken, a redirect target with a flush request. The register updates land on the next clock edge.

Trap entry finishes in a single cycle. The unit saves the resume PC, cause and fault value, moves the interrupt-enable bit into its stacked copy, and steers fetch to the direct-mode vector base. Interrupts are arbitrated at a fixed priority. An all-zero instruction word reported as illegal is treated as a no-op. A bank of 64-bit counters tracks cycles, retired instructions and eight pipeline event lines. All counters can be read and written as CSRs.

Top module: `mtrap_csr_unit`

## Requirements
- R1: After reset the status register (0x300) reads 0x0000_1800 (bits 12:11 fixed at 11, MIE bit 3 and MPIE bit 7 clear). The vector base (0x305), resume PC (0x341), cause (0x342), fault value (0x343), scratch (0x340) and enable (0x304) registers read zero, and no redirect is requested.
- R2: `csr_op` selects 1 write, 2 set, 3 clear, 5 write-immediate, 6 set-immediate and 7 clear-immediate. The immediate forms use `csr_idx` zero-extended as the operand, and the others use `csr_src`. `csr_rdata` returns the old value in the request cycle, and the new value is stored at the next edge.
- R3: The set and clear forms leave the register unchanged when `csr_idx` is zero. The write forms always store their operand.
- R4: The vector base and resume PC read bits 1:0 as zero. In the status register only bits 3 and 7 are writable.
- R5: The pending register (0x344) shows the external, timer and software lines at bits 11, 7 and 3. When several enabled interrupts are pending, external wins over software, and software wins over timer. Their cause values are 0x8000_000B, 0x8000_0003 and 0x8000_0007.
- R6: An interrupt is taken only when MIE is set and a line is pending with its enable bit (bit 11, 3 or 7 of 0x304) set. It is not taken in a cycle with a CSR request, an MRET request or an exception.
- R7: Exception priority is misaligned fetch (cause 0, fault value `exc_addr`), then illegal instruction (2, `exc_instr`), then breakpoint (3, `exc_pc`), then environment call (11, value 0), then misaligned load (4, `exc_addr`), then misaligned store (6, `exc_addr`).
- R8: On a trap, in the same cycle, `redirect` and `flush` rise with `redirect_pc` equal to the vector base. At the next edge the resume PC takes `exc_pc` for an exception or `irq_resume_pc` for an interrupt, MPIE takes MIE, and MIE clears. An exception beats an interrupt, and it cancels a CSR write in the same cycle.
- R9: MRET redirects to the resume PC in the same cycle. At the next edge MIE takes MPIE and MPIE is set.
- R10: An illegal-instruction request whose `exc_instr` is all zeros causes no trap and leaves the cause register unchanged.
- R11: The cycle counter (0xB00) counts every cycle, and the retired counter (0xB02) counts `retire` cycles. Event counter i (0xB03+i) counts cycles with `evt[i]` high. The upper halves sit at address+0x80 and carry out of the lower half. A CSR write to either half replaces that half and suppresses that cycle's increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_valid | input | 1 | CSR instruction at the commit point |
| csr_op | input | 3 | CSR operation code |
| csr_addr | input | 12 | CSR address |
| csr_idx | input | 5 | Source register index or 5-bit immediate |
| csr_src | input | 32 | Source register value |
| csr_rdata | output | 32 | Old CSR value |
| mret_req | input | 1 | MRET at the commit point |
| exc_fetch_mis | input | 1 | Misaligned fetch fault |
| exc_illegal | input | 1 | Illegal instruction fault |
| exc_ebreak | input | 1 | Breakpoint |
| exc_ecall | input | 1 | Environment call |
| exc_load_mis | input | 1 | Misaligned load fault |
| exc_store_mis | input | 1 | Misaligned store fault |
| exc_pc | input | 32 | PC of the faulting instruction |
| exc_instr | input | 32 | Faulting instruction word |
| exc_addr | input | 32 | Faulting address |
| irq_ext | input | 1 | External interrupt line |
| irq_sw | input | 1 | Software interrupt line |
| irq_tmr | input | 1 | Timer interrupt line |
| irq_resume_pc | input | 32 | PC of the next instruction to run |
| retire | input | 1 | One instruction retired this cycle |
| evt | input | 8 | Event lines for the event counters |
| redirect | output | 1 | Steer fetch to `redirect_pc` |
| redirect_pc | output | 32 | Redirect target |
| flush | output | 1 | Discard in-flight instructions |

## Verification
A wrong enable or stacked-enable bit appears in the next cycle as an interrupt taken or refused when it should not be, or as a status read with bits 3 and 7 swapped. A wrong arbitration or cause selection is visible in the cause and fault-value reads one cycle after the trap. A misplaced suppression shows as a scratch value that changes on a set or clear from index zero. Counter faults appear as read differences that do not match the exact number of cycles or pulses between two reads.

// File: rtl/mtrap_pkg.sv
`timescale 1ns/1ps
package mtrap_pkg;

   localparam logic [11:0] A_MSTATUS  = 12'h300;
   localparam logic [11:0] A_MIE      = 12'h304;
   localparam logic [11:0] A_MTVEC    = 12'h305;
   localparam logic [11:0] A_MSCRATCH = 12'h340;
   localparam logic [11:0] A_MEPC     = 12'h341;
   localparam logic [11:0] A_MCAUSE   = 12'h342;
   localparam logic [11:0] A_MTVAL    = 12'h343;
   localparam logic [11:0] A_MIP      = 12'h344;
   localparam logic [11:0] A_CTR_BASE = 12'hB00;
   localparam logic [11:0] A_CTR_HI   = 12'h080;

   typedef enum logic [1:0] {
      RMW_NONE  = 2'd0,
      RMW_WRITE = 2'd1,
      RMW_SET   = 2'd2,
      RMW_CLEAR = 2'd3
   } rmw_kind_e;

   localparam logic [4:0] CODE_FETCH_MIS = 5'd0;
   localparam logic [4:0] CODE_ILLEGAL   = 5'd2;
   localparam logic [4:0] CODE_BREAK     = 5'd3;
   localparam logic [4:0] CODE_LOAD_MIS  = 5'd4;
   localparam logic [4:0] CODE_STORE_MIS = 5'd6;
   localparam logic [4:0] CODE_ECALL     = 5'd11;
   localparam logic [4:0] CODE_IRQ_SW    = 5'd3;
   localparam logic [4:0] CODE_IRQ_TMR   = 5'd7;
   localparam logic [4:0] CODE_IRQ_EXT   = 5'd11;

   // counter 0 is the cycle counter, 1 the retired counter, 2.. the events
   function automatic logic [11:0] ctr_addr(input int unsigned k);
      return (k == 0) ? A_CTR_BASE : A_CTR_BASE + 12'(k + 1);
   endfunction

endpackage

// File: rtl/mtrap_csr_rmw.sv
`timescale 1ns/1ps
module mtrap_csr_rmw
   import mtrap_pkg::*;
#(
   parameter int XLEN  = 32,
   parameter int IDX_W = 5
) (
   input  logic [2:0]       op,
   input  logic [IDX_W-1:0] idx,
   input  logic [XLEN-1:0]  src,
   input  logic [XLEN-1:0]  old,
   output logic [XLEN-1:0]  wdata,
   output logic             wr_req
);

   rmw_kind_e       kind;
   logic [XLEN-1:0] opnd;

   assign kind = rmw_kind_e'(op[1:0]);
   assign opnd = op[2] ? XLEN'(idx) : src;

   always_comb begin
      wdata  = old;
      wr_req = 1'b0;
      case (kind)
         RMW_WRITE: begin
            wdata  = opnd;
            wr_req = 1'b1;
         end
         RMW_SET: begin
            wdata  = old | opnd;
            wr_req = |idx;
         end
         RMW_CLEAR: begin
            wdata  = old & ~opnd;
            wr_req = |idx;
         end
         default: begin
            wdata  = old;
            wr_req = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/mtrap_irq_pick.sv
`timescale 1ns/1ps
module mtrap_irq_pick #(
   parameter int                          NUM_SRC = 3,
   parameter int                          CODE_W  = 5,
   parameter logic [NUM_SRC*CODE_W-1:0]   CODES   = '0
) (
   input  logic [NUM_SRC-1:0] pend,
   output logic               valid,
   output logic [CODE_W-1:0]  code
);

   // index 0 has the highest priority
   always_comb begin
      valid = 1'b0;
      code  = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (pend[i]) begin
            valid = 1'b1;
            code  = CODES[i*CODE_W +: CODE_W];
         end
      end
   end

   always_comb begin
      if (pend == '0) assert (!valid);
   end

endmodule

// File: rtl/mtrap_ctr_slice.sv
`timescale 1ns/1ps
module mtrap_ctr_slice #(
   parameter int CNT_W = 64,
   parameter int XLEN  = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            inc,
   input  logic            wr_lo,
   input  logic            wr_hi,
   input  logic [XLEN-1:0] wdata,
   output logic [XLEN-1:0] lo,
   output logic [XLEN-1:0] hi
);

   logic [CNT_W-1:0] cnt_q, cnt_d, hi_ins, hi_msk;

   generate
      if (CNT_W > XLEN) begin : g_wide
         assign hi_ins = {wdata[CNT_W-XLEN-1:0], XLEN'(0)};
         assign hi_msk = {{(CNT_W-XLEN){1'b1}}, XLEN'(0)};
         assign hi     = XLEN'(cnt_q[CNT_W-1:XLEN]);
      end else begin : g_narrow
         assign hi_ins = '0;
         assign hi_msk = '0;
         assign hi     = '0;
      end
   endgenerate

   assign lo = cnt_q[XLEN-1:0];

   always_comb begin
      cnt_d = cnt_q + CNT_W'(inc);
      if (wr_lo || wr_hi) begin
         cnt_d = cnt_q;
         if (wr_lo) cnt_d[XLEN-1:0] = wdata;
         if (wr_hi) cnt_d = (cnt_d & ~hi_msk) | hi_ins;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   AST_CTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_lo && !wr_hi) |=> (cnt_q == $past(cnt_q) + CNT_W'($past(inc)))); // R11

endmodule

// File: rtl/mtrap_csr_unit.sv
`timescale 1ns/1ps
module mtrap_csr_unit
   import mtrap_pkg::*;
#(
   parameter int XLEN    = 32,
   parameter int NUM_EVT = 8,
   parameter int CNT_W   = 64
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               csr_valid,
   input  logic [2:0]         csr_op,
   input  logic [11:0]        csr_addr,
   input  logic [4:0]         csr_idx,
   input  logic [XLEN-1:0]    csr_src,
   output logic [XLEN-1:0]    csr_rdata,
   input  logic               mret_req,
   input  logic               exc_fetch_mis,
   input  logic               exc_illegal,
   input  logic               exc_ebreak,
   input  logic               exc_ecall,
   input  logic               exc_load_mis,
   input  logic               exc_store_mis,
   input  logic [XLEN-1:0]    exc_pc,
   input  logic [XLEN-1:0]    exc_instr,
   input  logic [XLEN-1:0]    exc_addr,
   input  logic               irq_ext,
   input  logic               irq_sw,
   input  logic               irq_tmr,
   input  logic [XLEN-1:0]    irq_resume_pc,
   input  logic               retire,
   input  logic [NUM_EVT-1:0] evt,
   output logic               redirect,
   output logic [XLEN-1:0]    redirect_pc,
   output logic               flush
);

   localparam int              NUM_CTR  = NUM_EVT + 2;
   localparam int              IDX_W    = 5;
   localparam logic [XLEN-1:0] PC_MASK  = {{(XLEN-2){1'b1}}, 2'b00};

   generate
      if (XLEN != 32) begin : g_bad_xlen
         $error("mtrap_csr_unit: XLEN must be 32");
      end
      if (NUM_EVT < 1 || NUM_EVT > 29) begin : g_bad_evt
         $error("mtrap_csr_unit: NUM_EVT must lie in 1..29");
      end
      if (CNT_W < XLEN || CNT_W > 2 * XLEN) begin : g_bad_cnt
         $error("mtrap_csr_unit: CNT_W must lie in XLEN..2*XLEN");
      end
   endgenerate

   // architectural state
   logic            st_mie, st_mpie;
   logic            en_ext, en_sw, en_tmr;
   logic [XLEN-1:0] mtvec_q, mepc_q, mcause_q, mtval_q, mscratch_q;

   // exception selection
   logic            ill_eff, exc_take;
   logic [4:0]      exc_code;
   logic [XLEN-1:0] exc_tval;

   assign ill_eff = exc_illegal && (exc_instr != '0);

   always_comb begin
      exc_take = 1'b1;
      exc_code = CODE_FETCH_MIS;
      exc_tval = '0;
      if (exc_fetch_mis) begin
         exc_code = CODE_FETCH_MIS;
         exc_tval = exc_addr;
      end else if (ill_eff) begin
         exc_code = CODE_ILLEGAL;
         exc_tval = exc_instr;
      end else if (exc_ebreak) begin
         exc_code = CODE_BREAK;
         exc_tval = exc_pc;
      end else if (exc_ecall) begin
         exc_code = CODE_ECALL;
      end else if (exc_load_mis) begin
         exc_code = CODE_LOAD_MIS;
         exc_tval = exc_addr;
      end else if (exc_store_mis) begin
         exc_code = CODE_STORE_MIS;
         exc_tval = exc_addr;
      end else begin
         exc_take = 1'b0;
      end
   end

   // interrupt arbitration: index 0 external, 1 software, 2 timer
   logic [2:0] irq_pend;
   logic       irq_any, irq_take;
   logic [4:0] irq_code;

   assign irq_pend = {irq_tmr & en_tmr, irq_sw & en_sw, irq_ext & en_ext};

   mtrap_irq_pick #(
      .NUM_SRC (3),
      .CODE_W  (5),
      .CODES   ({CODE_IRQ_TMR, CODE_IRQ_SW, CODE_IRQ_EXT})
   ) u_pick (
      .pend  (irq_pend),
      .valid (irq_any),
      .code  (irq_code)
   );

   assign irq_take = st_mie && irq_any && !exc_take && !mret_req && !csr_valid;

   logic trap_take, mret_take;
   assign trap_take   = exc_take | irq_take;
   assign mret_take   = mret_req && !exc_take;
   assign redirect    = trap_take | mret_take;
   assign flush       = redirect;
   assign redirect_pc = trap_take ? mtvec_q : mepc_q;

   // counters
   logic [XLEN-1:0] ctr_lo [NUM_CTR];
   logic [XLEN-1:0] ctr_hi [NUM_CTR];
   logic [XLEN-1:0] csr_wdata;
   logic            rmw_wr, csr_we;

   assign csr_we = csr_valid && rmw_wr && !exc_take;

   generate
      for (genvar k = 0; k < NUM_CTR; k++) begin : g_ctr
         logic inc_k;
         if (k == 0) begin : g_cycle
            assign inc_k = 1'b1;
         end else if (k == 1) begin : g_ret
            assign inc_k = retire;
         end else begin : g_evt
            assign inc_k = evt[k-2];
         end
         mtrap_ctr_slice #(
            .CNT_W (CNT_W),
            .XLEN  (XLEN)
         ) u_slice (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (inc_k),
            .wr_lo (csr_we && (csr_addr == ctr_addr(k))),
            .wr_hi (csr_we && (csr_addr == (ctr_addr(k) | A_CTR_HI))),
            .wdata (csr_wdata),
            .lo    (ctr_lo[k]),
            .hi    (ctr_hi[k])
         );
      end
   endgenerate

   // read side
   always_comb begin
      case (csr_addr)
         A_MSTATUS:  csr_rdata = {(XLEN-13)'(0), 2'b11, 3'b000, st_mpie, 3'b000, st_mie, 3'b000};
         A_MIE:      csr_rdata = {(XLEN-12)'(0), en_ext, 3'b000, en_tmr, 3'b000, en_sw, 3'b000};
         A_MIP:      csr_rdata = {(XLEN-12)'(0), irq_ext, 3'b000, irq_tmr, 3'b000, irq_sw, 3'b000};
         A_MTVEC:    csr_rdata = mtvec_q;
         A_MSCRATCH: csr_rdata = mscratch_q;
         A_MEPC:     csr_rdata = mepc_q;
         A_MCAUSE:   csr_rdata = mcause_q;
         A_MTVAL:    csr_rdata = mtval_q;
         default:    csr_rdata = '0;
      endcase
      for (int k = 0; k < NUM_CTR; k++) begin
         if (csr_addr == ctr_addr(k))              csr_rdata = ctr_lo[k];
         if (csr_addr == (ctr_addr(k) | A_CTR_HI)) csr_rdata = ctr_hi[k];
      end
   end

   mtrap_csr_rmw #(
      .XLEN  (XLEN),
      .IDX_W (IDX_W)
   ) u_rmw (
      .op     (csr_op),
      .idx    (csr_idx),
      .src    (csr_src),
      .old    (csr_rdata),
      .wdata  (csr_wdata),
      .wr_req (rmw_wr)
   );

   // state update
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_mie     <= 1'b0;
         st_mpie    <= 1'b0;
         en_ext     <= 1'b0;
         en_sw      <= 1'b0;
         en_tmr     <= 1'b0;
         mtvec_q    <= '0;
         mepc_q     <= '0;
         mcause_q   <= '0;
         mtval_q    <= '0;
         mscratch_q <= '0;
      end else if (trap_take) begin
         mepc_q   <= (exc_take ? exc_pc : irq_resume_pc) & PC_MASK;
         mcause_q <= exc_take ? XLEN'(exc_code) : {1'b1, (XLEN-1)'(irq_code)};
         mtval_q  <= exc_take ? exc_tval : '0;
         st_mpie  <= st_mie;
         st_mie   <= 1'b0;
      end else if (mret_take) begin
         st_mie  <= st_mpie;
         st_mpie <= 1'b1;
      end else if (csr_we) begin
         case (csr_addr)
            A_MSTATUS: begin
               st_mie  <= csr_wdata[3];
               st_mpie <= csr_wdata[7];
            end
            A_MIE: begin
               en_ext <= csr_wdata[11];
               en_tmr <= csr_wdata[7];
               en_sw  <= csr_wdata[3];
            end
            A_MTVEC:    mtvec_q    <= csr_wdata & PC_MASK;
            A_MEPC:     mepc_q     <= csr_wdata & PC_MASK;
            A_MCAUSE:   mcause_q   <= csr_wdata;
            A_MTVAL:    mtval_q    <= csr_wdata;
            A_MSCRATCH: mscratch_q <= csr_wdata;
            default: ;
         endcase
      end
   end

   AST_TRAP_STACKS_MIE: assert property (@(posedge clk) disable iff (!rst_n)
      trap_take |=> (!st_mie && st_mpie == $past(st_mie))); // R8

   AST_IRQ_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
      irq_take |=> (mcause_q[XLEN-1] && mepc_q == ($past(irq_resume_pc) & PC_MASK))); // R8

   AST_EXC_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
      exc_take |=> (!mcause_q[XLEN-1] && mepc_q == ($past(exc_pc) & PC_MASK))); // R7

   AST_MRET_UNSTACK: assert property (@(posedge clk) disable iff (!rst_n)
      mret_take |=> (st_mie == $past(st_mpie) && st_mpie)); // R9

   AST_SETCLR_ZERO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_valid && !exc_take && csr_op[1] && csr_idx == '0 && csr_addr == A_MSCRATCH)
      |=> $stable(mscratch_q)); // R3

   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (!st_mie && !exc_take && !mret_req) |-> !redirect); // R6

   AST_ZERO_WORD_NOP: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_illegal && exc_instr == '0 && !exc_fetch_mis && !exc_ebreak && !exc_ecall &&
       !exc_load_mis && !exc_store_mis && !irq_take && !mret_req) |-> !flush); // R10

endmodule

// File: tb/mtrap_csr_unit_tb.sv
`timescale 1ns/1ps
module mtrap_csr_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        csr_valid;
   logic [2:0]  csr_op;
   logic [11:0] csr_addr;
   logic [4:0]  csr_idx;
   logic [31:0] csr_src;
   logic [31:0] csr_rdata;
   logic        mret_req;
   logic        exc_fetch_mis, exc_illegal, exc_ebreak, exc_ecall, exc_load_mis, exc_store_mis;
   logic [31:0] exc_pc, exc_instr, exc_addr;
   logic        irq_ext, irq_sw, irq_tmr;
   logic [31:0] irq_resume_pc;
   logic        retire;
   logic [7:0]  evt;
   logic        redirect;
   logic [31:0] redirect_pc;
   logic        flush;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   mtrap_csr_unit dut_i (.*);

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic csr_do(input logic [2:0] op, input logic [11:0] a, input logic [4:0] idx,
                         input logic [31:0] s, output logic [31:0] r, output logic red);
      csr_valid = 1'b1; csr_op = op; csr_addr = a; csr_idx = idx; csr_src = s;
      #1;
      r   = csr_rdata;
      red = redirect;
      @(negedge clk);
      csr_valid = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] r);
      logic red;
      csr_do(3'd2, a, 5'd0, 32'h0, r, red);
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] v);
      logic [31:0] r;
      logic red;
      csr_do(3'd1, a, 5'd1, v, r, red);
   endtask

   task automatic clear_exc();
      exc_fetch_mis = 0; exc_illegal = 0; exc_ebreak = 0;
      exc_ecall = 0; exc_load_mis = 0; exc_store_mis = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog act=running exp=finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      logic [31:0] v, a, b;
      rst_n = 0; csr_valid = 0; csr_op = 0; csr_addr = 0; csr_idx = 0; csr_src = 0;
      mret_req = 0; clear_exc(); exc_pc = 0; exc_instr = 0; exc_addr = 0;
      irq_ext = 0; irq_sw = 0; irq_tmr = 0; irq_resume_pc = 0; retire = 0; evt = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R1 reset state
      rd(12'h300, v); check("R1 mstatus", v, 32'h0000_1800);
      rd(12'h305, v); check("R1 mtvec", v, 0);
      rd(12'h341, v); check("R1 mepc", v, 0);
      rd(12'h342, v); check("R1 mcause", v, 0);
      rd(12'h343, v); check("R1 mtval", v, 0);
      rd(12'h340, v); check("R1 mscratch", v, 0);
      rd(12'h304, v); check("R1 mie", v, 0);
      #1; check("R1 no redirect", {31'b0, redirect}, 0);

      // R2 / R3 read-modify-write sweep on the scratch register
      foreach (v[i]) ; // no-op keeps v declared in use
      for (int oi = 0; oi < 6; oi++) begin
         for (int ii = 0; ii < 3; ii++) begin
            logic [2:0]  op;
            logic [4:0]  idx;
            logic [31:0] pre, src, opnd, exp, old;
            logic        red;
            op  = (oi < 3) ? 3'(oi + 1) : 3'(oi + 2);
            idx = (ii == 0) ? 5'd0 : (ii == 1) ? 5'd5 : 5'd31;
            pre = 32'h5A5A_0F0F;
            src = 32'hF0F0_00F3;
            opnd = op[2] ? {27'b0, idx} : src;
            case (op[1:0])
               2'd1:    exp = opnd;
               2'd2:    exp = (idx == 0) ? pre : (pre | opnd);
               default: exp = (idx == 0) ? pre : (pre & ~opnd);
            endcase
            wr(12'h340, pre);
            csr_do(op, 12'h340, idx, src, old, red);
            check("R2 old value returned", old, pre);
            rd(12'h340, v);
            check((idx == 0 && op[1]) ? "R3 set/clear x0 no write" : "R2 new value", v, exp);
         end
      end

      // R4 masking
      wr(12'h305, 32'h0000_2003); rd(12'h305, v); check("R4 mtvec low bits", v, 32'h0000_2000);
      wr(12'h341, 32'h0000_1236); rd(12'h341, v); check("R4 mepc low bits", v, 32'h0000_1234);
      wr(12'h300, 32'hFFFF_FFFF); rd(12'h300, v); check("R4 mstatus writable bits", v, 32'h0000_1888);

      // R9 MRET
      wr(12'h300, 32'h0000_0080);
      mret_req = 1; #1;
      check("R9 mret redirect", {31'b0, redirect}, 1);
      check("R9 mret target", redirect_pc, 32'h0000_1234);
      @(negedge clk); mret_req = 0;
      rd(12'h300, v); check("R9 mret MIE<-MPIE", v, 32'h0000_1888);
      wr(12'h300, 32'h0000_0008);
      mret_req = 1; @(negedge clk); mret_req = 0;
      rd(12'h300, v); check("R9 mret MPIE set, MIE cleared", v, 32'h0000_1880);

      // R8 exception entry
      wr(12'h300, 32'h0000_0008);
      exc_ecall = 1; exc_pc = 32'h0000_0400; #1;
      check("R8 trap redirect", {31'b0, redirect}, 1);
      check("R8 trap flush", {31'b0, flush}, 1);
      check("R8 trap target", redirect_pc, 32'h0000_2000);
      @(negedge clk); clear_exc();
      rd(12'h300, v); check("R8 stack MIE", v, 32'h0000_1880);
      rd(12'h341, v); check("R8 mepc", v, 32'h0000_0400);
      rd(12'h342, v); check("R7 ecall cause", v, 32'd11);
      rd(12'h343, v); check("R7 ecall tval", v, 0);

      // R8 exception beats interrupt
      wr(12'h304, 32'h0000_0800);
      wr(12'h300, 32'h0000_0008);
      irq_ext = 1; exc_ebreak = 1; exc_pc = 32'h0000_0600; irq_resume_pc = 32'h0000_0700;
      @(negedge clk); clear_exc(); irq_ext = 0;
      rd(12'h342, v); check("R8 exception over interrupt cause", v, 32'd3);
      rd(12'h341, v); check("R8 exception over interrupt mepc", v, 32'h0000_0600);
      rd(12'h343, v); check("R7 ebreak tval", v, 32'h0000_0600);

      // R8 exception cancels the CSR write
      wr(12'h340, 32'h0000_1111);
      begin
         logic [31:0] r; logic red;
         exc_illegal = 1; exc_instr = 32'hFFFF_FFFF; exc_pc = 32'h0000_0800;
         csr_do(3'd1, 12'h340, 5'd3, 32'h0000_2222, r, red);
         clear_exc();
         check("R8 trap during csr redirect", {31'b0, red}, 1);
      end
      rd(12'h340, v); check("R8 csr write cancelled", v, 32'h0000_1111);
      rd(12'h342, v); check("R7 illegal cause", v, 32'd2);

      // R10 all-zero word
      exc_illegal = 1; exc_instr = 32'h0; #1;
      check("R10 zero word no redirect", {31'b0, redirect}, 0);
      @(negedge clk); clear_exc();
      rd(12'h342, v); check("R10 cause unchanged", v, 32'd2);

      // R7 exhaustive exception combination sweep
      for (int m = 1; m < 64; m++) begin
         logic [31:0] ecode, etval, pc, ins, adr;
         pc = 32'h0000_1000 + 32'(m) * 4;
         ins = 32'hDEAD_0000 | 32'(m);
         adr = 32'h0000_3001 + 32'(m);
         if (m[0])      begin ecode = 0;  etval = adr; end
         else if (m[1]) begin ecode = 2;  etval = ins; end
         else if (m[2]) begin ecode = 3;  etval = pc;  end
         else if (m[3]) begin ecode = 11; etval = 0;   end
         else if (m[4]) begin ecode = 4;  etval = adr; end
         else           begin ecode = 6;  etval = adr; end
         exc_fetch_mis = m[0]; exc_illegal = m[1]; exc_ebreak = m[2];
         exc_ecall = m[3]; exc_load_mis = m[4]; exc_store_mis = m[5];
         exc_pc = pc; exc_instr = ins; exc_addr = adr;
         #1;
         check("R7 sweep redirect", {31'b0, redirect}, 1);
         check("R8 sweep target", redirect_pc, 32'h0000_2000);
         @(negedge clk); clear_exc();
         rd(12'h342, v); check("R7 sweep cause", v, ecode);
         rd(12'h343, v); check("R7 sweep tval", v, etval);
         rd(12'h341, v); check("R8 sweep mepc", v, pc);
      end

      // R5 / R6 interrupt sweep over global enable, enable mask and lines
      for (int g = 0; g < 2; g++) begin
         for (int mk = 0; mk < 8; mk++) begin
            for (int ln = 0; ln < 8; ln++) begin
               logic [31:0] r, rpc, ecause;
               logic        red, take;
               logic [2:0]  act;
               act  = 3'(mk & ln);
               take = (g == 1) && (act != 0);
               ecause = act[0] ? 32'h8000_000B : act[1] ? 32'h8000_0003 : 32'h8000_0007;
               rpc = 32'h0000_4000 + 32'((g * 64 + mk * 8 + ln) * 4);
               irq_resume_pc = rpc;
               irq_ext = ln[0]; irq_sw = ln[1]; irq_tmr = ln[2];
               wr(12'h304, {20'b0, mk[0], 3'b0, mk[2], 3'b0, mk[1], 3'b0});
               wr(12'h300, (g == 1) ? 32'h8 : 32'h0);
               csr_do(3'd2, 12'h344, 5'd0, 32'h0, r, red);
               check("R5 pending view", r, {20'b0, ln[0], 3'b0, ln[2], 3'b0, ln[1], 3'b0});
               check("R6 no interrupt during csr", {31'b0, red}, 0);
               #1;
               check("R6 interrupt taken", {31'b0, redirect}, {31'b0, take});
               if (take) check("R8 interrupt target", redirect_pc, 32'h0000_2000);
               @(negedge clk);
               irq_ext = 0; irq_sw = 0; irq_tmr = 0;
               if (take) begin
                  rd(12'h342, v); check("R5 interrupt cause", v, ecause);
                  rd(12'h341, v); check("R8 interrupt mepc", v, rpc);
                  rd(12'h300, v); check("R8 interrupt stacks MIE", v, 32'h0000_1880);
               end
            end
         end
      end

      // R11 counters
      rd(12'hB00, a); repeat (10) @(negedge clk); rd(12'hB00, b);
      check("R11 cycle count", b - a, 32'd11);
      rd(12'hB02, a);
      retire = 1; repeat (5) @(negedge clk); retire = 0;
      rd(12'hB02, b);
      check("R11 retired count", b - a, 32'd5);
      for (int i = 0; i < 8; i++) begin
         evt = 8'(1 << i);
         repeat (i + 1) @(negedge clk);
         evt = 0;
      end
      for (int i = 0; i < 8; i++) begin
         rd(12'hB03 + 12'(i), v); check("R11 event low", v, 32'(i + 1));
         rd(12'hB83 + 12'(i), v); check("R11 event high", v, 0);
      end
      wr(12'hB00, 32'h0000_0100); rd(12'hB00, v); check("R11 cycle write wins", v, 32'h0000_0100);
      wr(12'hB80, 32'h0000_0007);
      wr(12'hB00, 32'hFFFF_FFFF);
      rd(12'hB80, v); check("R11 high before carry", v, 32'h0000_0007);
      rd(12'hB80, v); check("R11 carry into high", v, 32'h0000_0008);

      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule